// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Mirror

This block is the interrupt-status corner of a two-channel disk controller's configuration space. Each channel has one interrupt-pending flag, and software can see that flag at two byte addresses: a per-channel status register and a shared mode register. The flag is set or cleared by the level changes of the channel's interrupt line. It can also be cleared by software through a write-one-to-clear at either address. Whichever copy a write reaches, the other copy is brought into line in the same clock edge, so software never sees the two views disagree.

The shared mode register also holds one block bit per channel. The single level-sensitive request leaving the block is asserted while some channel is pending and not blocked. An enable register reports which channels are active. Its value is fixed when the block is elaborated.

All register reads are combinational on the address. Writes take effect at the rising clock edge where the write strobe is high. The request output is a flop that is loaded from the next-state values, so it follows the register contents with no extra delay.

Top module: `ide_irq_mirror`

## Requirements
- R1: After reset both pending flags and both block bits are 0 and irq_o is 0. Address 0x51 reads bit 2 set, and bit 3 set only when SECONDARY_EN is 1. Unmapped addresses read 0x00.
- R2: The channel 0 flag reads at 0x50 bit 2 and at 0x71 bit 2. The channel 1 flag reads at 0x57 bit 4 and at 0x71 bit 3. The block bits read at 0x71 bits 4 (channel 0) and 5 (channel 1). All other bits of 0x50, 0x57 and 0x71 read 0.
- R3: A 0-to-1 change on chan_irq_i[c] sets channel c's flag in both locations at the next edge. A 1-to-0 change clears it in both locations.
- R4: While a channel input holds steady and no write clears its flag, the flag keeps its value. A software clear made while the input stays high holds until the next input change.
- R5: A write to 0x50 with bit 2 set clears channel 0's flag in both locations. A write to 0x57 with bit 4 set clears channel 1's flag in both locations. Other data bits written to these addresses have no effect.
- R6: A write to 0x71 clears channel 0's flag when bit 2 is set and channel 1's flag when bit 3 is set, in both locations.
- R7: A write to 0x71 loads the block bits from data bits 4 and 5. Writes to any other address leave the block bits unchanged.
- R8: irq_o equals (flag0 AND NOT block0) OR (flag1 AND NOT block1), taken over the register contents visible in the same cycle.
- R9: When an input change on a channel and a software clear of that channel's flag land on the same edge, the input change decides the flag.
- R10: Writes to 0x51 or to unmapped addresses change no register.
- R11: The two copies of each channel's flag are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_irq_i | input | 2 | Interrupt level from channel 0 (bit 0) and channel 1 (bit 1) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| irq_o | output | 1 | Registered, level-sensitive combined interrupt request |

## Verification
The checker holds these properties in every cycle:
- the two copies of each flag agree;
- irq_o follows the flag and block combination;
- input edges set and clear the flags;
- a clear with no input change takes effect;
- the block bits load from a mode-register write.

Only the bench's scenarios can show the other behaviours. These are the exact bit placement of every field at each address, the ignoring of stray data bits and unmapped writes, and the read-only enable value. The bench also shows the edge-over-clear priority across both channels. It reaches these through near-exhaustive sweeps of write data against every address.

// File: rtl/ide_mirror_pkg.sv
package ide_mirror_pkg;
    localparam int NCH = 2;
    localparam int AW  = 8;
    localparam int DW  = 8;

    localparam logic [AW-1:0] ADR_ST0  = 8'h50;
    localparam logic [AW-1:0] ADR_EN   = 8'h51;
    localparam logic [AW-1:0] ADR_ST1  = 8'h57;
    localparam logic [AW-1:0] ADR_MODE = 8'h71;

    localparam int ST0_BIT       = 2;
    localparam int ST1_BIT       = 4;
    localparam int EN0_BIT       = 2;
    localparam int EN1_BIT       = 3;
    localparam int MODE_PEND_LSB = 2;
    localparam int MODE_BLK_LSB  = 4;
endpackage

// File: rtl/ide_chan_edge.sv
module ide_chan_edge
    import ide_mirror_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lvl_i,
    output logic [NCH-1:0] lvl_q_o,
    output logic [NCH-1:0] rise_o,
    output logic [NCH-1:0] fall_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q_o[g] <= 1'b0;
            else        lvl_q_o[g] <= lvl_i[g];
        end
        assign rise_o[g] =  lvl_i[g] & ~lvl_q_o[g];
        assign fall_o[g] = ~lvl_i[g] &  lvl_q_o[g];
    end
endmodule

// File: rtl/ide_pend_regs.sv
module ide_pend_regs
    import ide_mirror_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] rise,
    input  logic [NCH-1:0] fall,
    output logic [NCH-1:0] cpy_st,
    output logic [NCH-1:0] cpy_mode,
    output logic [NCH-1:0] blk,
    output logic [NCH-1:0] st_nxt,
    output logic [NCH-1:0] mode_nxt,
    output logic [NCH-1:0] blk_nxt
);
    logic mode_hit;
    assign mode_hit = we && (addr == ADR_MODE);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [AW-1:0] ST_ADR = (g == 0) ? ADR_ST0 : ADR_ST1;
        localparam int            ST_BIT = (g == 0) ? ST0_BIT : ST1_BIT;
        logic st_hit;
        assign st_hit = we && (addr == ST_ADR);

        // Apply the write to the copy it addresses, then mirror it into the other copy.
        // An input edge overrides both.
        always_comb begin
            st_nxt[g]   = cpy_st[g];
            mode_nxt[g] = cpy_mode[g];
            if (st_hit) begin
                st_nxt[g]   = cpy_st[g] & ~wdata[ST_BIT];
                mode_nxt[g] = st_nxt[g];
            end else if (mode_hit) begin
                mode_nxt[g] = cpy_mode[g] & ~wdata[MODE_PEND_LSB + g];
                st_nxt[g]   = mode_nxt[g];
            end
            if (rise[g]) begin
                st_nxt[g]   = 1'b1;
                mode_nxt[g] = 1'b1;
            end else if (fall[g]) begin
                st_nxt[g]   = 1'b0;
                mode_nxt[g] = 1'b0;
            end
        end
    end

    assign blk_nxt = mode_hit ? wdata[MODE_BLK_LSB +: NCH] : blk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpy_st   <= '0;
            cpy_mode <= '0;
            blk      <= '0;
        end else begin
            cpy_st   <= st_nxt;
            cpy_mode <= mode_nxt;
            blk      <= blk_nxt;
        end
    end
endmodule

// File: rtl/ide_irq_merge.sv
module ide_irq_merge
    import ide_mirror_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend_nxt,
    input  logic [NCH-1:0] blk_nxt,
    output logic           irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(pend_nxt & ~blk_nxt);
    end
endmodule

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror
    import ide_mirror_pkg::*;
#(
    parameter bit SECONDARY_EN = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     chan_irq_i,
    input  logic           cfg_we,
    input  logic [7:0]     cfg_addr,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    output logic           irq_o
);
    localparam logic [DW-1:0] EN_VAL =
        (DW'(1) << EN0_BIT) | (SECONDARY_EN ? (DW'(1) << EN1_BIT) : DW'(0));

    logic [NCH-1:0] lvl_q, rise, fall;
    logic [NCH-1:0] cpy_st, cpy_mode, blk;
    logic [NCH-1:0] st_nxt, mode_nxt, blk_nxt;

    ide_chan_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (chan_irq_i),
        .lvl_q_o (lvl_q),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    ide_pend_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rise     (rise),
        .fall     (fall),
        .cpy_st   (cpy_st),
        .cpy_mode (cpy_mode),
        .blk      (blk),
        .st_nxt   (st_nxt),
        .mode_nxt (mode_nxt),
        .blk_nxt  (blk_nxt)
    );

    ide_irq_merge u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (mode_nxt),
        .blk_nxt  (blk_nxt),
        .irq_o    (irq_o)
    );

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADR_ST0:  cfg_rdata[ST0_BIT] = cpy_st[0];
            ADR_ST1:  cfg_rdata[ST1_BIT] = cpy_st[1];
            ADR_EN:   cfg_rdata = EN_VAL;
            ADR_MODE: begin
                cfg_rdata[MODE_PEND_LSB +: NCH] = cpy_mode;
                cfg_rdata[MODE_BLK_LSB  +: NCH] = blk;
            end
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ide_irq_mirror_chk.sv
module ide_irq_mirror_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] chan_irq_i,
    input logic       cfg_we,
    input logic [7:0] cfg_addr,
    input logic [7:0] cfg_wdata,
    input logic       irq_o,
    input logic [1:0] lvl_q,
    input logic [1:0] cpy_st,
    input logic [1:0] cpy_mode,
    input logic [1:0] blk
);
    // R11
    copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpy_st == cpy_mode);

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(cpy_mode & ~blk));

    // R3
    rise0_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_irq_i[0] && !lvl_q[0]) |=> (cpy_mode[0] && cpy_st[0]));

    // R3
    rise1_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_irq_i[1] && !lvl_q[1]) |=> (cpy_mode[1] && cpy_st[1]));

    // R3
    fall0_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_irq_i[0] && lvl_q[0]) |=> !cpy_mode[0]);

    // R5
    st0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h50 && cfg_wdata[2] && chan_irq_i[0] == lvl_q[0])
        |=> !cpy_mode[0]);

    // R6
    mode1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h71 && cfg_wdata[3] && chan_irq_i[1] == lvl_q[1])
        |=> !cpy_st[1]);

    // R7
    blk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h71) |=> blk == $past(cfg_wdata[5:4]));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && chan_irq_i == lvl_q) |=> cpy_mode == $past(cpy_mode));
endmodule

bind ide_irq_mirror ide_irq_mirror_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_irq_i (chan_irq_i),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .irq_o      (irq_o),
    .lvl_q      (lvl_q),
    .cpy_st     (cpy_st),
    .cpy_mode   (cpy_mode),
    .blk        (blk)
);

// File: tb/tb_ide_irq_mirror.sv
module tb_ide_irq_mirror;
    localparam bit SEC = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan = 2'b00;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    logic [1:0] m_pend = 2'b00;
    logic [1:0] m_blk  = 2'b00;
    logic [1:0] m_prev = 2'b00;

    always #10 clk = ~clk;

    ide_irq_mirror #(.SECONDARY_EN(SEC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_irq_i (chan),
        .cfg_we     (we),
        .cfg_addr   (addr),
        .cfg_wdata  (wdata),
        .cfg_rdata  (rdata),
        .irq_o      (irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // R2 field layout, R8 combination
    task automatic check_state(string req);
        rd_check(req, 8'h50, {5'b0, m_pend[0], 2'b0});
        rd_check(req, 8'h57, {3'b0, m_pend[1], 4'b0});
        rd_check(req, 8'h71, {2'b0, m_blk, m_pend, 2'b0});
        check(req, {7'b0, irq}, {7'b0, |(m_pend & ~m_blk)});
    endtask

    // Drive one edge from a negedge; update the model; return at the next negedge.
    task automatic cycle(bit w, logic [7:0] a, logic [7:0] d, logic [1:0] ch);
        we = w; addr = a; wdata = d; chan = ch;
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            if (ch[c] != m_prev[c]) m_pend[c] = ch[c];
            else if (w && ((a == 8'h50 && c == 0 && d[2]) ||
                           (a == 8'h57 && c == 1 && d[4]) ||
                           (a == 8'h71 && d[2+c])))
                m_pend[c] = 1'b0;
        end
        if (w && a == 8'h71) m_blk = d[5:4];
        m_prev = ch;
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        rd_check("R1", 8'h51, 8'h0C);
        rd_check("R1", 8'h00, 8'h00);
        check_state("R1");

        // R2, R3, R8: every block pattern against every pending pattern
        for (int b = 0; b < 4; b++) begin
            for (int p = 0; p < 4; p++) begin
                cycle(1'b1, 8'h71, {2'b0, 2'(b), 4'b0}, 2'b00);
                cycle(1'b0, 8'h00, 8'h00, 2'(p));
                check_state("R8");
                cycle(1'b0, 8'h00, 8'h00, 2'b00);
                check_state("R3");
            end
        end

        // R5, R6, R7, R10: every data byte to each address with both flags armed
        for (int ai = 0; ai < 4; ai++) begin
            logic [7:0] a;
            a = (ai == 0) ? 8'h50 : (ai == 1) ? 8'h57 : (ai == 2) ? 8'h71 : 8'h51;
            for (int d = 0; d < 256; d++) begin
                cycle(1'b0, 8'h00, 8'h00, 2'b00);
                cycle(1'b0, 8'h00, 8'h00, 2'b11);
                cycle(1'b1, a, 8'(d), 2'b11);
                check_state((ai == 0 || ai == 1) ? "R5" : (ai == 2) ? "R6" : "R10");
            end
        end
        rd_check("R10", 8'h51, 8'h0C);
        cycle(1'b1, 8'h33, 8'hFF, 2'b11);
        check_state("R10");

        // R4: a cleared flag stays clear while the input holds high
        cycle(1'b1, 8'h71, 8'h00, 2'b00);
        cycle(1'b0, 8'h00, 8'h00, 2'b11);
        cycle(1'b1, 8'h71, 8'h0C, 2'b11);
        for (int k = 0; k < 4; k++) begin
            cycle(1'b0, 8'h00, 8'h00, 2'b11);
            check_state("R4");
        end

        // R9: an input edge on the same edge as a clear wins
        cycle(1'b0, 8'h00, 8'h00, 2'b00);
        cycle(1'b1, 8'h50, 8'h04, 2'b01);
        check_state("R9");
        check("R9", {7'b0, m_pend[0]}, 8'h01);
        cycle(1'b1, 8'h71, 8'h08, 2'b11);
        check_state("R9");
        check("R9", {6'b0, m_pend}, 8'h03);
        cycle(1'b1, 8'h57, 8'h10, 2'b01);
        check_state("R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule